// File: doc/BRIEF.md
# Clock-Configuring System Register Bank

This block is a bank of 32-bit control and status words sitting behind a simple word-addressed slave port with a select, a write enable, a byte address, write data and registered read data. Software reaches one word per access; the two low address bits are discarded, so every word occupies four byte addresses.

Two peripheral-bus clock divisors are fixed when the block is elaborated. Each must be a power of two no larger than 32, and an illegal value stops elaboration. On reset the bank loads two fixed PLL status words and a clock-control word in which both divisors appear in a compressed, non-linear code. The PLL status word and the three memory-remap control words refuse writes. Every other in-range word is plain read/write storage. An access beyond the bank returns zero, changes nothing and raises a one-cycle error flag.

Top module: `sysreg_bank`

## Requirements
- R1: The word index is the byte address shifted right by two. Address bits [1:0] never select a different word.
- R2: After reset, index 20 (byte 0x50) reads 0x021A2358 and index 21 (byte 0x54) reads 0x00000003.
- R3: After reset, the clock-control word at index 5 (byte 0x14) holds the bus-0 divisor code in bits [7:5] and the bus-1 divisor code in bits [4:2]. All other bits are zero. With both divisors at their default of 2 it reads 0x00000024.
- R4: The divisor code is the trailing-zero count of the divisor below 8 and that count plus one from 8 upward, mapping 1, 2, 4, 8, 16 and 32 to 0, 1, 2, 4, 5 and 6.
- R5: A divisor is legal only if it is a nonzero power of two no greater than 32. Elaboration with an illegal divisor fails.
- R6: A write to the PLL status word at index 21 leaves its contents unchanged.
- R7: Writes to the SRAM control word (index 0), the DDR control word (index 1) and the remap-base word (index 3) never change them.
- R8: A write to any other in-range word, the clock-control word included, stores all 32 bits, and later reads return that value.
- R9: A read at an index of 64 or more returns zero. A write there changes no word of the bank.
- R10: `err` is high, during the access cycle only, for a selected access at an index of 64 or more. It is low for in-range accesses and when `sel` is low.
- R11: Read data appears on `rdata` at the clock edge that ends the read-select cycle. It holds its value until the next read.
- R12: Reset is synchronous and active-high. It clears every word without a defined reset value to zero and takes priority over a write presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Access select for this cycle |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (10) | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | Out-of-range access flag, same cycle |

## Verification
Two functions can meet in one clock edge: reset and a store. The bench holds reset high while presenting a write to an ordinary word and the clock-control word. It then reads both back and expects zero and the divisor-coded reset word, not the written data. The second collision is an out-of-range access, which has to raise `err` in the access cycle and load zero into `rdata` at the same edge. The bench follows that access with an in-range read of the word the address would alias to if the upper index bits were dropped, and that word must be unchanged.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    localparam int DATA_W = 32;

    // Fixed word positions (word index, not byte address)
    localparam int IDX_SRAM_CTL = 0;
    localparam int IDX_DDR_CTL  = 1;
    localparam int IDX_REMAP    = 3;
    localparam int IDX_CLK_CTL  = 5;
    localparam int IDX_PLL_LO   = 20;
    localparam int IDX_PLL_ST   = 21;

    localparam logic [DATA_W-1:0] PLL_LO_INIT = 32'h021A_2358;
    localparam logic [DATA_W-1:0] PLL_ST_INIT = 32'h0000_0003;

    // Clock-control field layout
    localparam int CODE_W     = 3;
    localparam int BUS0_LSB   = 5;
    localparam int BUS1_LSB   = 2;

    // Per-cycle access classification
    typedef struct packed {
        logic rd;        // selected read
        logic wr_ok;     // selected write that may update storage
        logic in_range;  // index inside the bank
        logic err;       // selected access outside the bank
    } acc_t;

    function automatic bit div_legal(int unsigned d);
        return (d != 0) && (d <= 32) && ((d & (d - 1)) == 0);
    endfunction

    function automatic logic [CODE_W-1:0] div_code(int unsigned d);
        int unsigned tz;
        tz = 0;
        for (int i = 0; i < 6; i++) begin
            if (d == (32'd1 << i)) tz = i;
        end
        return (d < 8) ? CODE_W'(tz) : CODE_W'(tz + 1);
    endfunction

    function automatic logic [DATA_W-1:0] clk_word(int unsigned d0, int unsigned d1);
        logic [DATA_W-1:0] w;
        w = '0;
        w[BUS0_LSB +: CODE_W] = div_code(d0);
        w[BUS1_LSB +: CODE_W] = div_code(d1);
        return w;
    endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
    import sysreg_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int NREGS  = 64,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx,
    output acc_t              acc
);

    logic in_rng;
    logic locked;

    assign idx    = addr[ADDR_W-1:2];
    assign in_rng = (32'(idx) < NREGS);

    always_comb begin
        locked = 1'b0;
        if (idx == IDX_W'(IDX_PLL_ST))   locked = 1'b1;
        if (idx == IDX_W'(IDX_SRAM_CTL)) locked = 1'b1;
        if (idx == IDX_W'(IDX_DDR_CTL))  locked = 1'b1;
        if (idx == IDX_W'(IDX_REMAP))    locked = 1'b1;
    end

    always_comb begin
        acc.rd       = sel && !wr_en;
        acc.wr_ok    = sel && wr_en && in_rng && !locked;
        acc.in_range = in_rng;
        acc.err      = sel && !in_rng;
    end

    // R10: the error flag only ever accompanies a selected access
    assert_err_needs_sel_R10: assert property (@(posedge clk) disable iff (rst)
        acc.err |-> sel);

    // R6/R7: a permitted store never targets a protected word
    assert_no_store_locked_R7: assert property (@(posedge clk) disable iff (rst)
        acc.wr_ok |-> (addr[ADDR_W-1:2] != IDX_W'(IDX_PLL_ST))
                   && (addr[ADDR_W-1:2] != IDX_W'(IDX_REMAP)));

endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
    import sysreg_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int NREGS = 64,
    parameter logic [DATA_W-1:0] CLK_INIT = '0,
    localparam int RIDX_W = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  acc_t              acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [NREGS];
    logic [RIDX_W-1:0] ridx;

    assign ridx = idx[RIDX_W-1:0];

    function automatic logic [DATA_W-1:0] init_val(int i);
        if (i == IDX_PLL_LO)  return PLL_LO_INIT;
        if (i == IDX_PLL_ST)  return PLL_ST_INIT;
        if (i == IDX_CLK_CTL) return CLK_INIT;
        return '0;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) mem[i] <= init_val(i);
        end else if (acc.wr_ok) begin
            mem[ridx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          rdata <= '0;
        else if (acc.rd)  rdata <= acc.in_range ? mem[ridx] : '0;
    end

    assert_pll_status_locked_R6: assert property (@(posedge clk) disable iff (rst)
        acc.wr_ok || !acc.wr_ok |=> $stable(mem[IDX_PLL_ST]));

    assert_remap_locked_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mem[IDX_SRAM_CTL]) && $stable(mem[IDX_DDR_CTL])
                 && $stable(mem[IDX_REMAP]));

    assert_store_full_word_R8: assert property (@(posedge clk) disable iff (rst)
        acc.wr_ok |=> mem[$past(ridx)] == $past(wdata));

    assert_oob_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
        acc.rd && !acc.in_range |=> rdata == '0);

    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !acc.rd |=> $stable(rdata));

endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
    import sysreg_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int NREGS    = 64,
    parameter int BUS0_DIV = 2,
    parameter int BUS1_DIV = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [DATA_W-1:0] CLK_INIT = clk_word(BUS0_DIV, BUS1_DIV);

    // R5: refuse illegal divisors at elaboration
    if (!div_legal(BUS0_DIV) || !div_legal(BUS1_DIV)) begin : g_bad_div
        $error("sysreg_bank: divisors must be powers of two no greater than 32");
    end

    logic [IDX_W-1:0] idx;
    acc_t             acc;

    sysreg_decode #(
        .ADDR_W (ADDR_W),
        .NREGS  (NREGS)
    ) u_decode (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .wr_en (wr_en),
        .addr  (addr),
        .idx   (idx),
        .acc   (acc)
    );

    sysreg_store #(
        .IDX_W    (IDX_W),
        .NREGS    (NREGS),
        .CLK_INIT (CLK_INIT)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .idx   (idx),
        .acc   (acc),
        .wdata (wdata),
        .rdata (rdata)
    );

    assign err = acc.err;

    // R10: an out-of-range selected address always flags
    assert_err_on_oob_R10: assert property (@(posedge clk) disable iff (rst)
        sel && (32'(addr) >= NREGS * 4) |-> err);

    // R10: an in-range address never flags
    assert_no_err_in_range_R10: assert property (@(posedge clk) disable iff (rst)
        (32'(addr) < NREGS * 4) |-> !err);

endmodule

// File: tb/sysreg_bank_tb.sv
module sysreg_bank_tb;
    import sysreg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysreg_bank u_dut (
        .clk(clk), .rst(rst), .sel(sel), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .err(err)
    );

    // {is_write, addr[9:0], wdata[31:0], expect[31:0], exp_err, tag[3:0]}
    localparam int NV = 23;
    localparam logic [79:0] VEC [NV] = '{
        {1'b0, 10'h050, 32'h0, 32'h021A_2358, 1'b0, 4'd2},  // R2 PLL low status
        {1'b0, 10'h054, 32'h0, 32'h0000_0003, 1'b0, 4'd2},  // R2 PLL status
        {1'b0, 10'h014, 32'h0, 32'h0000_0024, 1'b0, 4'd3},  // R3 clock word
        {1'b1, 10'h054, 32'hFFFF_FFFF, 32'h0, 1'b0, 4'd6},  // R6
        {1'b0, 10'h054, 32'h0, 32'h0000_0003, 1'b0, 4'd6},  // R6
        {1'b1, 10'h000, 32'hDEAD_BEEF, 32'h0, 1'b0, 4'd7},  // R7 SRAM
        {1'b0, 10'h000, 32'h0, 32'h0, 1'b0, 4'd7},          // R7
        {1'b1, 10'h004, 32'h1111_2222, 32'h0, 1'b0, 4'd7},  // R7 DDR
        {1'b0, 10'h004, 32'h0, 32'h0, 1'b0, 4'd7},          // R7
        {1'b1, 10'h00C, 32'h3333_4444, 32'h0, 1'b0, 4'd7},  // R7 remap
        {1'b0, 10'h00C, 32'h0, 32'h0, 1'b0, 4'd7},          // R7
        {1'b1, 10'h020, 32'hA5A5_5A5A, 32'h0, 1'b0, 4'd8},  // R8
        {1'b0, 10'h020, 32'h0, 32'hA5A5_5A5A, 1'b0, 4'd8},  // R8
        {1'b1, 10'h023, 32'h1234_5678, 32'h0, 1'b0, 4'd1},  // R1 low bits
        {1'b0, 10'h022, 32'h0, 32'h1234_5678, 1'b0, 4'd1},  // R1
        {1'b1, 10'h120, 32'hFFFF_FFFF, 32'h0, 1'b1, 4'd9},  // R9 oob write
        {1'b0, 10'h020, 32'h0, 32'h1234_5678, 1'b0, 4'd9},  // R9 alias untouched
        {1'b0, 10'h120, 32'h0, 32'h0, 1'b1, 4'd9},          // R9 oob read
        {1'b1, 10'h0FC, 32'h8000_0001, 32'h0, 1'b0, 4'd8},  // R8 last word
        {1'b0, 10'h0FC, 32'h0, 32'h8000_0001, 1'b0, 4'd8},  // R8
        {1'b0, 10'h100, 32'h0, 32'h0, 1'b1, 4'd10},         // R10 first oob word
        {1'b1, 10'h014, 32'h0000_0077, 32'h0, 1'b0, 4'd8},  // R8 clock word writable
        {1'b0, 10'h014, 32'h0, 32'h0000_0077, 1'b0, 4'd8}   // R8
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    // Drive at negedge; err sampled mid-cycle; data sampled after the edge
    task automatic access(bit w, logic [9:0] a, logic [31:0] d,
                          output logic e, output logic [31:0] q);
        @(negedge clk);
        sel = 1'b1; wr_en = w; addr = a; wdata = d;
        #1 e = err;
        @(posedge clk);
        #1 q = rdata;
        sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin : watchdog
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL R11 watchdog actual=timeout expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : main
        logic e;
        logic [31:0] q, held;

        do_reset();

        // R12: reset state of a plain word, and no error while idle
        access(1'b0, 10'h008, 32'h0, e, q);
        check("R12 plain word resets to zero", q, 32'h0);
        #1 check("R10 idle err low", {31'b0, err}, 32'h0);

        // R4/R5: divisor code and legality functions
        check("R4 code(1)",  {29'b0, div_code(1)},  32'd0);
        check("R4 code(8)",  {29'b0, div_code(8)},  32'd4);
        check("R4 code(32)", {29'b0, div_code(32)}, 32'd6);
        check("R5 legal(16)", {31'b0, div_legal(16)}, 32'd1);
        check("R5 illegal(0)", {31'b0, div_legal(0)}, 32'd0);
        check("R5 illegal(12)", {31'b0, div_legal(12)}, 32'd0);
        check("R5 illegal(64)", {31'b0, div_legal(64)}, 32'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [79:0] v;
            v = VEC[i];
            access(v[79], v[78:69], v[68:37], e, q);
            check($sformatf("R%0d err vector %0d", v[3:0], i), {31'b0, e}, {31'b0, v[4]});
            if (!v[79])
                check($sformatf("R%0d data vector %0d", v[3:0], i), q, v[36:5]);
        end

        // R10: err is a single-cycle pulse
        access(1'b0, 10'h3FC, 32'h0, e, q);
        check("R10 err on top address", {31'b0, e}, 32'h1);
        #1 check("R10 err drops after access", {31'b0, err}, 32'h0);

        // R11: registered read timing and hold
        access(1'b0, 10'h050, 32'h0, e, q);
        held = q;
        @(negedge clk);
        sel = 1'b1; wr_en = 1'b0; addr = 10'h054;
        #1 check("R11 rdata not yet updated", rdata, held);
        @(posedge clk); #1 check("R11 rdata after edge", rdata, 32'h3);
        sel = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 rdata holds while idle", rdata, 32'h3);

        // R12: reset wins over a write in the same cycle
        access(1'b1, 10'h030, 32'h5555_AAAA, e, q);
        @(negedge clk);
        rst = 1'b1; sel = 1'b1; wr_en = 1'b1; addr = 10'h030; wdata = 32'hABCD_0123;
        @(negedge clk);
        addr = 10'h014; wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        rst = 1'b0; sel = 1'b0; wr_en = 1'b0;
        access(1'b0, 10'h030, 32'h0, e, q);
        check("R12 reset beats write", q, 32'h0);
        access(1'b0, 10'h014, 32'h0, e, q);
        check("R3 clock word restored by reset", q, 32'h0000_0024);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule